// File: doc/BRIEF.md
# Wait-Stretching Single-Register Bus Slave

This block is a slave on a 6502-style parallel expansion bus that holds one 8-bit read/write register. The bus master selects it with an active-low chip select and a single read/write line; there are no address inputs. From that one direction line the block derives two separate strobes: a read output-enable that drives the data bus, and a one-clock write-enable pulse that loads the register. The data bus is split into an input, an output and an output-enable, so the pad logic stays outside the block.

A slow target often cannot finish an access inside the short half-cycle data phase. To give it time, the block pulls its ready output low once it sees chip select. A down-counter then holds it low for a set number of bus cycles, `WAIT_CYCLES`, which defaults to one. The master repeats a cycle for as long as it samples ready low at the falling edge of the phase clock. The block changes ready only while the phase clock is low, and it moves data only in the last cycle of the access, the first one after ready has returned high. Setting `WAIT_CYCLES` to 0 removes the counter, and every access then completes in one bus cycle.

The logic runs on a fast fabric clock `clk` and samples the phase clock `phi2` as a synchronous input. A finite-state machine has three states:
- **ST_IDLE**: waiting for chip select.
- **ST_HOLD**: ready is held low while the counter runs.
- **ST_XFER**: the final data phase.

Its transitions are:
- **start-wait**: ST_IDLE to ST_HOLD, taken when chip select is seen during the low phase and `WAIT_CYCLES` is above 0.
- **start-direct**: ST_IDLE to ST_XFER, taken when chip select is seen during the low phase and `WAIT_CYCLES` is 0.
- **count-out**: ST_HOLD to ST_XFER, taken at the phase-clock fall where the counter expires.
- **finish**: ST_XFER to ST_IDLE, taken at the phase-clock fall that closes the data phase.

Top module: `bsr_wait_slave`

## Requirements
- R1: After reset the stored value is 0x00 and ready is high. The output-enable and write strobe are both low, and the output bus reads 0x00.
- R2: A read is signalled by chip select low and read/write high (1 = read, 0 = write). In the final data phase of a read, while `phi2` is high, `d_oe` is 1 and `d_out` carries the stored value. At every other time `d_oe` is 0 and `d_out` is 0x00.
- R3: With `WAIT_CYCLES` above 0, ready falls no later than the third `clk` edge after chip select goes low in a low phase of `phi2`.
- R4: For a selected access, the master samples ready low at exactly `WAIT_CYCLES` consecutive falling edges of `phi2`, then high at the next one. Ready rises only at the first `clk` edge after a `phi2` fall has been sampled.
- R5: Ready never changes at a `clk` edge where `phi2` is high.
- R6: A write produces exactly one write-strobe pulse, one `clk` long, after the final phase closes. It loads the data present during the high half of that phase, and ready is high while the pulse is active.
- R7: During the stretched (ready low) cycles of a read, `d_oe` stays 0.
- R8: Bus cycles with chip select high leave ready high and the stored value unchanged, whatever the read/write line and data bus carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fabric clock, at least four periods per `phi2` half-cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| phi2 | input | 1 | Bus phase clock; high is the data phase |
| cs_n | input | 1 | Active-low chip select |
| rw | input | 1 | 1 = read, 0 = write |
| d_in | input | 8 | Data bus as driven by the master |
| d_out | output | 8 | Data bus value driven by this slave, 0 when not driving |
| d_oe | output | 1 | Read output-enable strobe for the data bus |
| we_stb | output | 1 | One-clock write-enable strobe that loads the register |
| rdy | output | 1 | Ready to the master; low stretches the bus cycle |

## Verification
Two functions land on the same `clk` edge during back-to-back accesses with no idle cycle between them. The write commit that closes one access (finish) falls on the edge where the next access's chip select is already being sampled. The bench provokes this with directed write-write and write-read pairs and with random sequences that often omit idle cycles. It judges the result in three ways: the next access must still see exactly `WAIT_CYCLES` stretched cycles, the write-strobe count must match the number of writes, and a later read must return the last written byte.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2
    } bsr_state_e;

    function automatic int cnt_width(input int waits);
        int w;
        w = $clog2(waits + 1);
        return (w < 1) ? 1 : w;
    endfunction

endpackage

// File: rtl/bsr_bus_sample.sv
module bsr_bus_sample #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi2,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [DW-1:0] d_in,
    output logic          sel_q,
    output logic          rw_q,
    output logic          phi_high,
    output logic          fall,
    output logic          hp_sel,
    output logic          hp_rw,
    output logic [DW-1:0] hp_d
);

    logic phi_q;
    logic phi_qq;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi_q  <= 1'b0;
            phi_qq <= 1'b0;
            sel_q  <= 1'b0;
            rw_q   <= 1'b1;
        end else begin
            phi_q  <= phi2;
            phi_qq <= phi_q;
            sel_q  <= ~cs_n;
            rw_q   <= rw;
        end
    end

    // Snapshot of the bus taken while the data phase is high; used at the fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hp_sel <= 1'b0;
            hp_rw  <= 1'b1;
            hp_d   <= '0;
        end else if (phi2) begin
            hp_sel <= ~cs_n;
            hp_rw  <= rw;
            hp_d   <= d_in;
        end
    end

    assign phi_high = phi_q;
    assign fall     = phi_qq & ~phi_q;

endmodule

// File: rtl/bsr_wait_timer.sv
module bsr_wait_timer #(
    parameter int WAIT_CYCLES = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic dec,
    output logic last
);

    localparam int CW = bsr_pkg::cnt_width(WAIT_CYCLES);

    generate
        if (WAIT_CYCLES == 0) begin : g_none
            logic unused_inputs;
            assign unused_inputs = clk ^ rst_n ^ load ^ dec;
            assign last = 1'b1;
        end else begin : g_count
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (load) begin
                    cnt <= CW'(WAIT_CYCLES);
                end else if (dec) begin
                    cnt <= cnt - 1'b1;
                end
            end

            assign last = (cnt == CW'(1));

            a_r4_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
                dec |-> (cnt != '0));
        end
    endgenerate

endmodule

// File: rtl/bsr_strobe_split.sv
module bsr_strobe_split #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_xfer,
    input  logic          sel_q,
    input  logic          rw_q,
    input  logic          phi_high,
    input  logic          fall,
    input  logic          hp_sel,
    input  logic          hp_rw,
    input  logic [DW-1:0] store_q,
    output logic          rd_en,
    output logic          we_pulse,
    output logic [DW-1:0] d_out
);

    always_comb begin
        rd_en    = in_xfer & sel_q & rw_q & phi_high;
        we_pulse = in_xfer & fall & hp_sel & ~hp_rw;
        d_out    = rd_en ? store_q : '0;
    end

    a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && we_pulse));

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        we_pulse |=> !we_pulse);

endmodule

// File: rtl/bsr_wait_slave.sv
module bsr_wait_slave #(
    parameter int DW          = 8,
    parameter int WAIT_CYCLES = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          phi2,
    input  logic          cs_n,
    input  logic          rw,
    input  logic [DW-1:0] d_in,
    output logic [DW-1:0] d_out,
    output logic          d_oe,
    output logic          we_stb,
    output logic          rdy
);

    import bsr_pkg::*;

    bsr_state_e    state;
    bsr_state_e    nxt;
    logic          sel_q;
    logic          rw_q;
    logic          phi_high;
    logic          fall;
    logic          hp_sel;
    logic          hp_rw;
    logic [DW-1:0] hp_d;
    logic          t_load;
    logic          t_dec;
    logic          t_last;
    logic          rd_en;
    logic          we_pulse;
    logic [DW-1:0] store_q;
    logic          rdy_q;
    logic          rdy_d;

    bsr_bus_sample #(.DW(DW)) u_sample (
        .clk      (clk),
        .rst_n    (rst_n),
        .phi2     (phi2),
        .cs_n     (cs_n),
        .rw       (rw),
        .d_in     (d_in),
        .sel_q    (sel_q),
        .rw_q     (rw_q),
        .phi_high (phi_high),
        .fall     (fall),
        .hp_sel   (hp_sel),
        .hp_rw    (hp_rw),
        .hp_d     (hp_d)
    );

    bsr_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (t_load),
        .dec   (t_dec),
        .last  (t_last)
    );

    // Next state and timer control
    always_comb begin
        nxt    = state;
        t_load = 1'b0;
        t_dec  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (sel_q && !phi_high) begin
                    if (WAIT_CYCLES == 0) begin
                        nxt = ST_XFER;
                    end else begin
                        nxt    = ST_HOLD;
                        t_load = 1'b1;
                    end
                end
            end
            ST_HOLD: begin
                if (fall) begin
                    t_dec = 1'b1;
                    if (t_last) begin
                        nxt = ST_XFER;
                    end
                end
            end
            ST_XFER: begin
                if (fall) begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        rdy_d = (nxt != ST_HOLD);
    end

    // State register and the single ready flip-flop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            rdy_q <= 1'b1;
        end else begin
            state <= nxt;
            rdy_q <= rdy_d;
        end
    end

    bsr_strobe_split #(.DW(DW)) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_xfer  (state == ST_XFER),
        .sel_q    (sel_q),
        .rw_q     (rw_q),
        .phi_high (phi_high),
        .fall     (fall),
        .hp_sel   (hp_sel),
        .hp_rw    (hp_rw),
        .store_q  (store_q),
        .rd_en    (rd_en),
        .we_pulse (we_pulse),
        .d_out    (d_out)
    );

    // The one data register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (we_pulse) begin
            store_q <= hp_d;
        end
    end

    // Outputs
    always_comb begin
        d_oe   = rd_en;
        we_stb = we_pulse;
        rdy    = rdy_q;
    end

    a_r3_select_pulls_rdy: assert property (@(posedge clk) disable iff (!rst_n)
        ((WAIT_CYCLES > 0) && (state == ST_IDLE) && sel_q && !phi_high) |=> !rdy);

    a_r4_release_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> $past(fall));

    a_r5_rdy_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $past(phi2) |-> $stable(rdy));

    a_r6_write_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        we_pulse |-> rdy);

    a_r7_oe_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> rdy);

endmodule

// File: tb/tb_bsr_wait_slave.sv
module tb_bsr_wait_slave;

    localparam int TB_WAIT = 2;
    localparam int N_RAND  = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       phi2 = 1'b0;
    logic       cs_n = 1'b1;
    logic       rw = 1'b1;
    logic [7:0] d_in = 8'h00;
    logic [7:0] d_out;
    logic       d_oe;
    logic       we_stb;
    logic       rdy;

    int checks = 0;
    int errors = 0;
    int wr_seen = 0;
    int wr_exp = 0;
    int rdy_viol = 0;
    logic prev_rdy = 1'b1;
    logic [7:0] model = 8'h00;
    bit done = 0;

    always #5 clk = ~clk;

    bsr_wait_slave #(.DW(8), .WAIT_CYCLES(TB_WAIT)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .phi2   (phi2),
        .cs_n   (cs_n),
        .rw     (rw),
        .d_in   (d_in),
        .d_out  (d_out),
        .d_oe   (d_oe),
        .we_stb (we_stb),
        .rdy    (rdy)
    );

    // Monitor: settled values just after each rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) begin
            if (we_stb) wr_seen++;
            if (rdy !== prev_rdy && phi2 === 1'b1) rdy_viol++;
        end
        prev_rdy = rdy;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_waits(input int kind);
        return (kind == 0) ? 0 : TB_WAIT;
    endfunction

    function automatic logic [7:0] exp_read(input int kind);
        return (kind == 2) ? model : 8'h00;
    endfunction

    // One master access, repeated while ready is sampled low at the phase fall
    task automatic bus_cycle(input logic c_n, input logic r, input logic [7:0] d,
                             output int waits, output logic [7:0] rdata,
                             output logic oe_fin, output logic oe_wait,
                             output logic rdy_early);
        int it = 0;
        logic rs;
        logic oe_s;
        logic [7:0] do_s;
        waits = 0;
        oe_wait = 1'b0;
        rdy_early = 1'b1;
        do begin
            phi2 = 1'b0; cs_n = c_n; rw = r; d_in = d;
            repeat (3) @(negedge clk);
            if (it == 0) begin
                rdy_early = rdy;
                chk(wr_seen == wr_exp, "R6", "write strobe count", wr_seen, wr_exp);
            end
            @(negedge clk);
            phi2 = 1'b1;
            repeat (3) @(negedge clk);
            oe_s = d_oe;
            do_s = d_out;
            @(negedge clk);
            rs = rdy;
            if (!rs) begin
                waits++;
                if (oe_s) oe_wait = 1'b1;
            end
            it++;
        end while (!rs && it < 64);
        oe_fin = oe_s;
        rdata = do_s;
    endtask

    // kind: 0 = deselected cycle, 1 = write, 2 = read
    task automatic do_op(input int kind, input logic [7:0] data, input logic rw_idle);
        int w;
        logic [7:0] rd;
        logic oef;
        logic oew;
        logic early;
        logic r;
        r = (kind == 2) ? 1'b1 : ((kind == 1) ? 1'b0 : rw_idle);
        bus_cycle((kind == 0), r, data, w, rd, oef, oew, early);
        if (kind == 0) begin
            chk(w == 0, "R8", "stretch on deselected cycle", w, 0);
            chk(early == 1'b1, "R8", "ready while deselected", early, 1);
        end else begin
            chk(w == exp_waits(kind), "R4", "stretched cycles", w, exp_waits(kind));
            chk(early == 1'b0, "R3", "ready low after select", early, 0);
        end
        if (kind == 2) begin
            chk(oew == 1'b0, "R7", "output enable during wait", oew, 0);
            chk(oef == 1'b1, "R2", "output enable on read", oef, 1);
        end else begin
            chk(oef == 1'b0, "R2", "output enable off", oef, 0);
        end
        chk(rd == exp_read(kind), "R2", "data out", rd, exp_read(kind));
        if (kind == 1) begin
            model = data;
            wr_exp++;
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd24681);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(rdy == 1'b1, "R1", "ready after reset", rdy, 1);
        chk(d_oe == 1'b0, "R1", "output enable after reset", d_oe, 0);
        chk(we_stb == 1'b0, "R1", "write strobe after reset", we_stb, 0);
        chk(d_out == 8'h00, "R1", "data out after reset", d_out, 0);
        do_op(2, 8'h00, 1'b1);            // R1: stored value reads 0x00
        // Directed cases
        do_op(1, 8'hA5, 1'b0);
        do_op(2, 8'h00, 1'b1);
        do_op(0, 8'hFF, 1'b0);            // R8: deselected write-shaped cycles
        do_op(0, 8'h11, 1'b0);
        do_op(0, 8'h22, 1'b1);
        do_op(2, 8'h00, 1'b1);            // still 0xA5
        do_op(1, 8'h3C, 1'b0);            // back-to-back writes, then read
        do_op(1, 8'hC3, 1'b0);
        do_op(2, 8'h00, 1'b1);
        do_op(1, 8'h00, 1'b0);
        do_op(1, 8'hFF, 1'b0);
        do_op(2, 8'h00, 1'b1);
        // Constrained random mix
        for (int i = 0; i < N_RAND; i++) begin
            int k;
            k = $urandom_range(0, 9);
            k = (k < 2) ? 0 : ((k < 6) ? 1 : 2);
            do_op(k, 8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)));
        end
        do_op(0, 8'h00, 1'b1);            // flush: last write strobe counted here
        chk(rdy_viol == 0, "R5", "ready changes in high phase", rdy_viol, 0);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule